// File: doc/BRIEF.md
# Serial Presence-Data EEPROM Slave

This block models a small two-wire serial EEPROM of 256 bytes, the kind that holds the presence data of a memory module. A host does not drive a real bus into it. Instead, the host writes the SCL and SDA levels it wants, one pair per write strobe. The slave compares each written pair with the levels from the previous write. From that comparison it finds start and stop conditions and clock rising edges, and it answers with a single SDA level.

A frame has a fixed shape. After a start, eight clocked bits form a command byte, and an acknowledge follows. Eight more clocked bits form an array address. When the command asks for a read, the slave uses those same eight clocks to shift out its data register, most significant bit first. After the eighth address bit, the data register is reloaded from the array at the address just received. A second acknowledge follows, and the slave returns to idle. As a result, a read frame returns the byte that the previous frame addressed. The array contents are loaded through a parallel initialisation port, and the bus has no path that writes to the array.

Top module: `serial_prom_slave`

## Requirements
- R1: While reset is asserted and after it is released, `sda_out` is 1, no frame is active, no acknowledge is pending and the data register is 0, so the first read frame after reset shifts out eight 0 bits.
- R2: A host write that keeps SCL at 1 (previous level 1, new level 1) while SDA goes from 1 to 0 is a start condition. A start sets the bit position to the first command bit, clears the command register and drops any pending acknowledge. The same situation with SDA going from 0 to 1 is a stop condition, which returns the slave to idle and drops any pending acknowledge. Start and stop are checked before any other action and can interrupt a frame at any point.
- R3: When the slave is idle (no frame and no acknowledge pending), every host write other than a start leaves `sda_out` at 1 and changes nothing else.
- R4: Within a frame, the first eight valid SCL rising edges shift the written SDA level into the command register. The first bit sent ends up as bit 7 and the last bit sent as bit 0. `sda_out` is 1 on these edges. The next SCL rising edge drives `sda_out` to 0 as an acknowledge. A pending acknowledge is served on any SCL rising edge, whatever SDA does.
- R5: Command bit 0 (the last command bit sent) selects read when 1 and write when 0. In write mode, `sda_out` stays 1 on the eight address edges and the data register is not shifted.
- R6: In read mode, on each of the eight address edges `sda_out` takes bit 7 of the data register, and the data register then shifts left with a 0 entering at bit 0.
- R7: The eight address bits arrive most significant bit first. On the eighth address edge the data register is loaded with the array byte at the full received address, in both modes. The next SCL rising edge drives the acknowledge, and the slave is then idle until the next start.
- R8: With `init_we` at 1 on a clock edge, `init_data` is stored at array location `init_addr`, whatever the bus is doing.
- R9: An SCL rising edge on which SDA also changes, and with no acknowledge pending, causes no bit action. The bit position does not advance, nothing shifts and `sda_out` is 1.
- R10: `sda_out` changes only on clock edges with `host_wr` at 1. It holds its value between host writes. A host write sets it to 0 only for an acknowledge or a 0 read-data bit, and to 1 in every other case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr | input | 1 | Host write strobe for the line levels |
| host_scl | input | 1 | SCL level written by the host |
| host_sda | input | 1 | SDA level written by the host |
| init_we | input | 1 | Array initialisation write enable |
| init_addr | input | ADDR_W | Array initialisation address |
| init_data | input | 8 | Array initialisation data |
| sda_out | output | 1 | SDA level presented by the slave (1 = released) |

## Verification
The assertions check these properties on every cycle:
- Bus conditions take effect on the next cycle: a start arms the frame, and a stop empties it.
- An idle slave keeps SDA released.
- A pending acknowledge is served on the next rising edge and then cleared.
- An SDA change on a rising edge leaves the bit position unchanged.
- In write mode the address phase presents nothing.
- The output only moves on host writes.
- The bit position never passes the last address bit.

Only the bench's scenarios can show the following:
- The command and address bits are actually counted correctly, as seen in where the acknowledges fall.
- Each frame returns the byte addressed by the frame before it.
- Zeros fill the data register after an interrupted read.
- Bytes loaded through the initialisation port reach the bus.

// File: rtl/serial_prom_pkg.sv
package serial_prom_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CMD_BITS = 8;

  // Classification of one host write against the previous line levels.
  typedef enum logic [2:0] {
    EV_NONE,
    EV_START,
    EV_STOP,
    EV_RISE,
    EV_RISE_BAD
  } bus_ev_e;

endpackage

// File: rtl/serial_prom_rstsync.sv
module serial_prom_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES < 2) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_chain
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/serial_prom_linesamp.sv
module serial_prom_linesamp
  import serial_prom_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    host_wr,
  input  logic    host_scl,
  input  logic    host_sda,
  output logic    scl_q,
  output logic    sda_q,
  output bus_ev_e ev
);

  logic scl_d;
  logic sda_d;

  // Event decode: a bus condition outranks any clock edge.
  always_comb begin
    ev = EV_NONE;
    if (host_wr) begin
      if (scl_q && host_scl && (sda_q != host_sda)) begin
        ev = host_sda ? EV_STOP : EV_START;
      end else if (!scl_q && host_scl) begin
        ev = (sda_q == host_sda) ? EV_RISE : EV_RISE_BAD;
      end
    end
  end

  // Previous-level store, enabled by the host write strobe.
  always_comb begin
    scl_d = scl_q;
    sda_d = sda_q;
    if (host_wr) begin
      scl_d = host_scl;
      sda_d = host_sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

endmodule

// File: rtl/serial_prom_array.sv
module serial_prom_array
  import serial_prom_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/serial_prom_frame.sv
module serial_prom_frame
  import serial_prom_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      host_wr,
  input  logic                                      bit_in,
  input  bus_ev_e                                   ev,
  input  logic [BYTE_W-1:0]                         rd_data,
  output logic [ADDR_W-1:0]                         rd_addr,
  output logic [$clog2(CMD_BITS+ADDR_W+1)-1:0]      tick_o,
  output logic                                      ack_o,
  output logic [CMD_BITS-1:0]                       cmd_o,
  output logic                                      sda_o
);

  localparam int unsigned TICK_LAST = CMD_BITS + ADDR_W;
  localparam int unsigned TICK_W    = $clog2(TICK_LAST + 1);

  logic [TICK_W-1:0]   tick_q, tick_d;
  logic                ack_q, ack_d;
  logic [CMD_BITS-1:0] cmd_q, cmd_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [BYTE_W-1:0]   data_q, data_d;
  logic                sdo_q, sdo_d;
  logic                in_cmd;
  logic                active;

  assign in_cmd  = (tick_q <= TICK_W'(CMD_BITS));
  assign active  = (tick_q != '0);
  // Address as it stands after the bit on the current edge.
  assign rd_addr = {addr_q[ADDR_W-2:0], bit_in};

  always_comb begin
    tick_d = tick_q;
    ack_d  = ack_q;
    cmd_d  = cmd_q;
    addr_d = addr_q;
    data_d = data_q;
    sdo_d  = sdo_q;
    if (host_wr) begin
      sdo_d = 1'b1;
      unique case (ev)
        EV_START: begin
          tick_d = TICK_W'(1);
          cmd_d  = '0;
          ack_d  = 1'b0;
        end
        EV_STOP: begin
          tick_d = '0;
          ack_d  = 1'b0;
        end
        EV_RISE, EV_RISE_BAD: begin
          if (ack_q) begin
            sdo_d = 1'b0;
            ack_d = 1'b0;
          end else if ((ev == EV_RISE) && active) begin
            if (in_cmd) begin
              cmd_d  = {cmd_q[CMD_BITS-2:0], bit_in};
              tick_d = tick_q + TICK_W'(1);
              if (tick_q == TICK_W'(CMD_BITS)) begin
                ack_d = 1'b1;
              end
            end else begin
              if (cmd_q[0]) begin
                sdo_d  = data_q[BYTE_W-1];
                data_d = {data_q[BYTE_W-2:0], 1'b0};
              end
              addr_d = rd_addr;
              if (tick_q == TICK_W'(TICK_LAST)) begin
                data_d = rd_data;
                ack_d  = 1'b1;
                tick_d = '0;
              end else begin
                tick_d = tick_q + TICK_W'(1);
              end
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      ack_q  <= 1'b0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      sdo_q  <= 1'b1;
    end else begin
      tick_q <= tick_d;
      ack_q  <= ack_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      data_q <= data_d;
      sdo_q  <= sdo_d;
    end
  end

  assign tick_o = tick_q;
  assign ack_o  = ack_q;
  assign cmd_o  = cmd_q;
  assign sda_o  = sdo_q;

endmodule

// File: rtl/serial_prom_slave.sv
module serial_prom_slave
  import serial_prom_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_scl,
  input  logic              host_sda,
  input  logic              init_we,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [BYTE_W-1:0] init_data,
  output logic              sda_out
);

  localparam int unsigned TICK_LAST = CMD_BITS + ADDR_W;
  localparam int unsigned TICK_W    = $clog2(TICK_LAST + 1);

  logic                rst_sync_n;
  logic                scl_q;
  logic                sda_q;
  bus_ev_e             ev;
  logic [ADDR_W-1:0]   rd_addr;
  logic [BYTE_W-1:0]   rd_data;
  logic [TICK_W-1:0]   tick_q;
  logic                ack_q;
  logic [CMD_BITS-1:0] cmd_q;

  serial_prom_rstsync #(
    .STAGES (SYNC_STAGES)
  ) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  serial_prom_linesamp u_linesamp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .host_wr  (host_wr),
    .host_scl (host_scl),
    .host_sda (host_sda),
    .scl_q    (scl_q),
    .sda_q    (sda_q),
    .ev       (ev)
  );

  serial_prom_array #(
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk     (clk),
    .wr_en   (init_we),
    .wr_addr (init_addr),
    .wr_data (init_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  serial_prom_frame #(
    .ADDR_W (ADDR_W)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .host_wr (host_wr),
    .bit_in  (host_sda),
    .ev      (ev),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .tick_o  (tick_q),
    .ack_o   (ack_q),
    .cmd_o   (cmd_q),
    .sda_o   (sda_out)
  );

endmodule

// File: rtl/serial_prom_chk.sv
module serial_prom_chk
  import serial_prom_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 host_wr,
  input logic                                 host_scl,
  input logic                                 host_sda,
  input logic                                 sda_out,
  input logic [$clog2(CMD_BITS+ADDR_W+1)-1:0] tick,
  input logic                                 ack_pend,
  input logic [CMD_BITS-1:0]                  cmd,
  input logic                                 scl_prev,
  input logic                                 sda_prev
);

  localparam int unsigned TICK_LAST = CMD_BITS + ADDR_W;
  localparam int unsigned TICK_W    = $clog2(TICK_LAST + 1);

  logic rise;
  assign rise = host_wr && !scl_prev && host_scl;

  // R2
  start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && scl_prev && host_scl && sda_prev && !host_sda
    |=> (tick == TICK_W'(1)) && (cmd == '0) && !ack_pend);

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && scl_prev && host_scl && !sda_prev && host_sda
    |=> (tick == '0) && !ack_pend);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && (tick == '0) && !ack_pend |=> sda_out);

  // R4
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise && ack_pend |=> !sda_out && !ack_pend);

  // R5
  write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise && !ack_pend && (tick > TICK_W'(CMD_BITS)) && !cmd[0] |=> sda_out);

  // R9
  glitch_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise && (host_sda != sda_prev) && !ack_pend |=> $stable(tick) && sda_out);

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(sda_out));

  // R7
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= TICK_W'(TICK_LAST));

endmodule

bind serial_prom_slave serial_prom_chk #(
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .host_wr  (host_wr),
  .host_scl (host_scl),
  .host_sda (host_sda),
  .sda_out  (sda_out),
  .tick     (tick_q),
  .ack_pend (ack_q),
  .cmd      (cmd_q),
  .scl_prev (scl_q),
  .sda_prev (sda_q)
);

// File: tb/test_serial_prom_slave.sv
module test_serial_prom_slave;

  localparam int CLK_P = 10;
  localparam int AW    = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_wr;
  logic          host_scl;
  logic          host_sda;
  logic          init_we;
  logic [AW-1:0] init_addr;
  logic [7:0]    init_data;
  logic          sda_out;

  int   vectors = 0;
  int   fails   = 0;
  bit   done    = 1'b0;
  logic cur_sda = 1'b1;
  logic [7:0] dreg;          // expected data register
  logic [7:0] model [256];   // expected array contents

  always #(CLK_P/2) clk = ~clk;

  serial_prom_slave #(.ADDR_W(AW)) i_serial_prom_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_scl  (host_scl),
    .host_sda  (host_sda),
    .init_we   (init_we),
    .init_addr (init_addr),
    .init_data (init_data),
    .sda_out   (sda_out)
  );

  function automatic logic [7:0] pat(int a, int seed);
    return 8'((a * 73 + seed * 41 + 29) & 255);
  endfunction

  task automatic hw(input logic s, input logic d);
    @(negedge clk);
    host_wr  = 1'b1;
    host_scl = s;
    host_sda = d;
    cur_sda  = d;
    @(negedge clk);
    host_wr  = 1'b0;
  endtask

  task automatic chk(input logic exp, input string req, input string what);
    vectors++;
    if (sda_out !== exp) begin
      fails++;
      $display("FAIL %s %s: sda_out=%b expected %b", req, what, sda_out, exp);
    end
  endtask

  task automatic init_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    init_we   = 1'b1;
    init_addr = AW'(a);
    init_data = d;
    model[a]  = d;
    @(negedge clk);
    init_we   = 1'b0;
  endtask

  task automatic start_c();
    hw(1'b0, 1'b1);
    hw(1'b1, 1'b1);
    hw(1'b1, 1'b0);
    chk(1'b1, "R2", "start");
    hw(1'b0, 1'b0);
    chk(1'b1, "R2", "after start");
  endtask

  task automatic stop_c();
    hw(1'b0, 1'b0);
    hw(1'b1, 1'b0);
    hw(1'b1, 1'b1);
    chk(1'b1, "R2", "stop");
  endtask

  task automatic bitc(input logic b, input logic exp, input string req, input string what);
    hw(1'b0, b);
    hw(1'b1, b);
    chk(exp, req, what);
    hw(1'b0, b);
    chk(1'b1, "R10", "low phase");
  endtask

  task automatic ackc(input string req);
    hw(1'b0, 1'b1);
    hw(1'b1, 1'b1);
    chk(1'b0, req, "ack");
    hw(1'b0, 1'b1);
    chk(1'b1, "R10", "ack release");
  endtask

  // Full frame; viol selects a command bit before which a glitch edge is inserted.
  task automatic xact(input logic [7:0] cmd, input logic [7:0] a, input int viol);
    start_c();
    for (int i = 7; i >= 0; i--) begin
      if (viol == 7 - i) begin
        logic v;
        v = ~cur_sda;
        hw(1'b1, v);
        chk(1'b1, "R9", "glitch edge");
        hw(1'b0, v);
      end
      bitc(cmd[i], 1'b1, "R4", "command bit");
    end
    ackc("R4");
    for (int i = 7; i >= 0; i--) begin
      logic e;
      if (cmd[0]) begin
        e    = dreg[7];
        dreg = {dreg[6:0], 1'b0};
        bitc(a[i], e, "R6", "read data bit");
      end else begin
        bitc(a[i], 1'b1, "R5", "write-mode address bit");
      end
    end
    ackc("R7");
    dreg = model[a];
    stop_c();
  endtask

  initial begin
    rst_n     = 1'b0;
    host_wr   = 1'b0;
    host_scl  = 1'b1;
    host_sda  = 1'b1;
    init_we   = 1'b0;
    init_addr = '0;
    init_data = '0;
    dreg      = 8'h00;
    repeat (3) @(negedge clk);
    chk(1'b1, "R1", "in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(1'b1, "R1", "after reset");

    // R3: clocks with no start do nothing
    for (int k = 0; k < 6; k++) begin
      bitc(k[0], 1'b1, "R3", "idle clock");
    end

    // R8: load the whole array through the init port
    for (int a = 0; a < 256; a++) begin
      init_wr(a, pat(a, 0));
    end

    // R1: first read returns zeros; then R6/R7 sweep over every address
    for (int a = 0; a < 256; a++) begin
      xact(8'hA1, 8'(a), -1);
    end

    // R5: write-mode frames still load the data register
    for (int k = 0; k < 16; k++) begin
      xact(8'hA0, 8'(k * 17 + 3), -1);
      xact(8'hA1, 8'(k * 5), -1);
    end

    // R9: a glitch edge at each command bit position
    for (int v = 0; v < 8; v++) begin
      xact(8'hA1, 8'(v * 31), v);
    end

    // R2: stop aborts a command, later edges are ignored
    start_c();
    bitc(1'b1, 1'b1, "R2", "partial command");
    bitc(1'b0, 1'b1, "R2", "partial command");
    bitc(1'b1, 1'b1, "R2", "partial command");
    bitc(1'b0, 1'b1, "R2", "partial command");
    bitc(1'b0, 1'b1, "R2", "partial command");
    stop_c();
    for (int k = 0; k < 3; k++) begin
      bitc(1'b1, 1'b1, "R2", "after stop");
    end
    xact(8'hA1, 8'h44, -1);

    // R2: restart inside a read address phase; shifted zeros remain (R6)
    start_c();
    for (int i = 7; i >= 0; i--) begin
      bitc(8'hA1 >> i & 1, 1'b1, "R4", "command bit");
    end
    ackc("R4");
    for (int i = 0; i < 3; i++) begin
      logic e;
      e    = dreg[7];
      dreg = {dreg[6:0], 1'b0};
      bitc(1'b0, e, "R6", "read data bit");
    end
    hw(1'b0, 1'b1);
    hw(1'b1, 1'b1);
    chk(dreg[7], "R6", "fourth data bit");
    dreg = {dreg[6:0], 1'b0};
    hw(1'b1, 1'b0);
    chk(1'b1, "R2", "restart");
    hw(1'b0, 1'b0);
    xact(8'hA1, 8'h90, -1);

    // R8: rewrite locations and read them back over the bus
    for (int a = 0; a < 8; a++) begin
      init_wr(a * 32, pat(a * 32, 1));
    end
    for (int a = 0; a < 8; a++) begin
      xact(8'hA1, 8'(a * 32), -1);
    end
    xact(8'hA1, 8'h00, -1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog expired: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule